// File: doc/BRIEF.md
# Table-Driven DMA Channel Scheduler

This block chooses which DMA channel, and in which direction, receives the next transfer opportunity. A host fills a table of slots. Each slot names one of 32 channels and marks the slot as receive or transmit. The scheduler walks the active part of the table in order and examines one slot per clock. It offers a grant only for a slot whose channel is ready in the named direction, and it skips every other slot. The number of slots that name a channel sets that channel's share of the opportunities, in steps of one table slot.

The host reaches the block through a simple register write port. Table words are write-only and read back as zero. A control word holds the index of the last active slot and an enable bit. Both the table and the control word can be rewritten while the scheduler runs, and the new values are used from the next slot examined. A grant is presented with a valid/acknowledge handshake. It holds its channel and direction until it is acknowledged. The walk then resumes at the slot after the granted one.

Top module: `dma_slot_sched`

## Requirements
- R1: After reset the scheduler is disabled, the last-slot index is 0, every slot holds channel 0 transmit, the pointer is at slot 0 and gnt_valid is low. Setting only the enable bit with tx_ready[0] high therefore yields a grant for channel 0, transmit.
- R2: A write to address w (0 to 63) loads slots 4w to 4w+3. Byte k of the data (bits 8k+7 down to 8k) goes to slot 4w+k. In each byte, bits [4:0] are the channel and bit 7 is the direction (1 means receive, 0 means transmit). Bits [6:5] have no effect on the grant.
- R3: Address 64 is the control word: bits [7:0] hold the last-slot index and bit 31 holds the enable. host_rdata shows the control word at address 64 and reads zero at addresses 0 to 63. Writes to addresses above 64 have no effect.
- R4: While the block is enabled and no grant is pending, it examines the slot at the pointer on each clock. If that slot's ready bit (rx_ready[ch] for receive, tx_ready[ch] for transmit) is high, gnt_valid rises on the next clock with that channel and direction, and the pointer stays. Otherwise the pointer moves on.
- R5: The slot after the last-slot index is slot 0. If the pointer lies above a newly lowered last-slot index, it returns to slot 0 without granting.
- R6: A grant keeps gnt_ch and gnt_rx stable until gnt_ack is high on a clock, even if the ready inputs drop. On that clock gnt_valid falls and the pointer moves to the following slot.
- R7: While the block is disabled, no grant is issued. Clearing the enable bit withdraws a pending grant on the next clock and leaves the pointer where it is.
- R8: Table and control writes made while the block is enabled take effect from the next slot examined, with no need to disable it.
- R9: With every requester ready and every grant acknowledged at once, each channel receives grants in proportion to the number of active slots that name it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_wr | input | 1 | Host register write strobe |
| host_addr | input | 7 | Host word address: table words, then the control word |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data (control word only, table reads zero) |
| tx_ready | input | 32 | Per-channel transmit ready |
| rx_ready | input | 32 | Per-channel receive ready |
| gnt_valid | output | 1 | Grant offered |
| gnt_ack | input | 1 | Grant accepted |
| gnt_ch | output | 5 | Granted channel |
| gnt_rx | output | 1 | Granted direction, 1 is receive |

## Verification
A wrong pointer shows as a grant for the wrong slot, or a grant out of order. The cycle-accurate reference catches it on the first grant after the fault, which comes within one pass over the active slots when all requesters are ready. A corrupted table slot shows up the next time the walk reaches that slot. A fault in the hold or withdraw logic appears as a change of gnt_valid, gnt_ch or gnt_rx in the very cycle it happens. Long runs with random ready inputs, random acknowledges and table rewrites made while the block runs sweep the pointer across every wrap and shrink case.

// File: rtl/dma_sched_pkg.sv
package dma_sched_pkg;
  localparam int CH_W      = 5;
  localparam int SLOT_BITS = 8;
  localparam int RX_BIT    = 7;
  localparam int HOST_DW   = 32;
  localparam int EN_BIT    = 31;

  typedef struct packed {
    logic            rx;
    logic [CH_W-1:0] ch;
  } slot_t;

  function automatic slot_t decode_slot(input logic [SLOT_BITS-1:0] b);
    slot_t s;
    s.rx = b[RX_BIT];
    s.ch = b[CH_W-1:0];
    return s;
  endfunction
endpackage

// File: rtl/dma_sched_regs.sv
module dma_sched_regs
  import dma_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 256,
  localparam int NUM_WORDS = NUM_SLOTS / 4,
  localparam int WORD_AW   = $clog2(NUM_WORDS),
  localparam int ADDR_W    = WORD_AW + 1,
  localparam int IDX_W     = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic [IDX_W-1:0]   rd_idx,
  output slot_t              rd_slot,
  output logic [IDX_W-1:0]   ctl_last,
  output logic               ctl_en
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_WORDS);

  slot_t tbl [NUM_SLOTS];

  logic               wr_tbl, wr_ctl;
  logic [WORD_AW-1:0] word_idx;
  logic [IDX_W-1:0]   last_d;
  logic               en_d;

  always_comb begin
    wr_tbl   = host_wr && (host_addr < CTRL_ADDR);
    wr_ctl   = host_wr && (host_addr == CTRL_ADDR);
    word_idx = host_addr[WORD_AW-1:0];
    last_d   = wr_ctl ? host_wdata[IDX_W-1:0] : ctl_last;
    en_d     = wr_ctl ? host_wdata[EN_BIT]    : ctl_en;
  end

  for (genvar e = 0; e < NUM_SLOTS; e++) begin : g_slot
    localparam int WI = e / 4;
    localparam int BI = e % 4;
    logic  ld;
    slot_t nxt;
    always_comb begin
      ld  = wr_tbl && (word_idx == WI[WORD_AW-1:0]);
      nxt = decode_slot(host_wdata[BI*SLOT_BITS +: SLOT_BITS]);
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  tbl[e] <= '0;
      else if (ld) tbl[e] <= nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_last <= '0;
      ctl_en   <= 1'b0;
    end else if (wr_ctl) begin
      ctl_last <= last_d;
      ctl_en   <= en_d;
    end
  end

  always_comb begin
    rd_slot    = tbl[rd_idx];
    host_rdata = '0;
    if (host_addr == CTRL_ADDR) begin
      host_rdata[IDX_W-1:0] = ctl_last;
      host_rdata[EN_BIT]    = ctl_en;
    end
  end
endmodule

// File: rtl/dma_sched_ready_sel.sv
module dma_sched_ready_sel
  import dma_sched_pkg::*;
#(
  localparam int NUM_CH = 1 << CH_W
) (
  input  slot_t             slot,
  input  logic [NUM_CH-1:0] tx_ready,
  input  logic [NUM_CH-1:0] rx_ready,
  output logic              slot_ready
);
  always_comb begin
    slot_ready = slot.rx ? rx_ready[slot.ch] : tx_ready[slot.ch];
  end
endmodule

// File: rtl/dma_sched_walker.sv
module dma_sched_walker
  import dma_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 256,
  localparam int IDX_W = $clog2(NUM_SLOTS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ctl_en,
  input  logic [IDX_W-1:0] ctl_last,
  input  slot_t           cur_slot,
  input  logic            cur_ready,
  input  logic            gnt_ack,
  output logic [IDX_W-1:0] ptr,
  output logic            gnt_valid,
  output slot_t           gnt_slot
);
  logic [IDX_W-1:0] ptr_d, ptr_succ;
  logic             valid_d, in_range, hit, load;

  always_comb begin
    in_range = (ptr <= ctl_last);
    ptr_succ = (ptr >= ctl_last) ? '0 : ptr + 1'b1;
    hit      = in_range && cur_ready;
    load     = 1'b0;
    ptr_d    = ptr;
    valid_d  = gnt_valid;
    if (!ctl_en) begin
      valid_d = 1'b0;
    end else if (gnt_valid) begin
      if (gnt_ack) begin
        valid_d = 1'b0;
        ptr_d   = ptr_succ;
      end
    end else if (hit) begin
      valid_d = 1'b1;
      load    = 1'b1;
    end else begin
      ptr_d = ptr_succ;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr       <= '0;
      gnt_valid <= 1'b0;
    end else begin
      ptr       <= ptr_d;
      gnt_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    gnt_slot <= '0;
    else if (load) gnt_slot <= cur_slot;
  end
endmodule

// File: rtl/dma_slot_sched.sv
module dma_slot_sched
  import dma_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 256,
  localparam int NUM_CH  = 1 << CH_W,
  localparam int ADDR_W  = $clog2(NUM_SLOTS / 4) + 1,
  localparam int IDX_W   = $clog2(NUM_SLOTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_wr,
  input  logic [ADDR_W-1:0]  host_addr,
  input  logic [HOST_DW-1:0] host_wdata,
  output logic [HOST_DW-1:0] host_rdata,
  input  logic [NUM_CH-1:0]  tx_ready,
  input  logic [NUM_CH-1:0]  rx_ready,
  output logic               gnt_valid,
  input  logic               gnt_ack,
  output logic [CH_W-1:0]    gnt_ch,
  output logic               gnt_rx
);
  logic [1:0]       rst_pipe;
  logic             rst_n_sync;
  slot_t            cur_slot, gnt_slot;
  logic             cur_ready, ctl_en;
  logic [IDX_W-1:0] ctl_last, ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_sync = rst_pipe[1];

  dma_sched_regs #(.NUM_SLOTS(NUM_SLOTS)) i_regs (
    .clk(clk), .rst_n(rst_n_sync),
    .host_wr(host_wr), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .rd_idx(ptr), .rd_slot(cur_slot),
    .ctl_last(ctl_last), .ctl_en(ctl_en)
  );

  dma_sched_ready_sel i_rsel (
    .slot(cur_slot), .tx_ready(tx_ready), .rx_ready(rx_ready),
    .slot_ready(cur_ready)
  );

  dma_sched_walker #(.NUM_SLOTS(NUM_SLOTS)) i_walk (
    .clk(clk), .rst_n(rst_n_sync), .ctl_en(ctl_en), .ctl_last(ctl_last),
    .cur_slot(cur_slot), .cur_ready(cur_ready), .gnt_ack(gnt_ack),
    .ptr(ptr), .gnt_valid(gnt_valid), .gnt_slot(gnt_slot)
  );

  assign gnt_ch = gnt_slot.ch;
  assign gnt_rx = gnt_slot.rx;
endmodule

// File: rtl/dma_slot_sched_checks.sv
module dma_slot_sched_checks
  import dma_sched_pkg::*;
#(
  parameter int NUM_SLOTS = 256,
  localparam int NUM_CH  = 1 << CH_W,
  localparam int ADDR_W  = $clog2(NUM_SLOTS / 4) + 1,
  localparam int IDX_W   = $clog2(NUM_SLOTS)
) (
  input logic               clk,
  input logic               rst_n_sync,
  input logic               ctl_en,
  input logic [IDX_W-1:0]   ctl_last,
  input logic [IDX_W-1:0]   ptr,
  input logic               gnt_valid,
  input logic               gnt_ack,
  input logic [CH_W-1:0]    gnt_ch,
  input logic               gnt_rx,
  input logic [NUM_CH-1:0]  tx_ready,
  input logic [NUM_CH-1:0]  rx_ready,
  input logic [ADDR_W-1:0]  host_addr,
  input logic [HOST_DW-1:0] host_rdata
);
  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SLOTS / 4);
  localparam logic [NUM_CH-1:0] ONE = NUM_CH'(1);

  // R6
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    gnt_valid && !gnt_ack && ctl_en |=> gnt_valid && $stable(gnt_ch) && $stable(gnt_rx));

  // R7
  disabled_idle_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !ctl_en |=> !gnt_valid);

  // R4
  grant_ready_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    $rose(gnt_valid) |-> (((gnt_rx ? $past(rx_ready) : $past(tx_ready)) >> gnt_ch) & ONE) != '0);

  // R3
  table_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    host_addr < CTRL_ADDR |-> host_rdata == '0);

  // R5
  ptr_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n_sync)
    ptr > ctl_last && ctl_en && !gnt_valid |=> ptr == '0);
endmodule

bind dma_slot_sched dma_slot_sched_checks #(.NUM_SLOTS(NUM_SLOTS)) i_checks (
  .clk(clk), .rst_n_sync(rst_n_sync), .ctl_en(ctl_en), .ctl_last(ctl_last),
  .ptr(ptr), .gnt_valid(gnt_valid), .gnt_ack(gnt_ack), .gnt_ch(gnt_ch),
  .gnt_rx(gnt_rx), .tx_ready(tx_ready), .rx_ready(rx_ready),
  .host_addr(host_addr), .host_rdata(host_rdata)
);

// File: tb/test_dma_slot_sched.sv
module test_dma_slot_sched;
  localparam int CLK_PERIOD = 10;
  localparam logic [6:0] CTRL = 7'd64;

  logic        clk, rst_n, host_wr, gnt_ack, gnt_valid, gnt_rx;
  logic [6:0]  host_addr;
  logic [31:0] host_wdata, host_rdata, tx_ready, rx_ready;
  logic [4:0]  gnt_ch;

  dma_slot_sched i_dma_slot_sched (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_ready(tx_ready),
    .rx_ready(rx_ready), .gnt_valid(gnt_valid), .gnt_ack(gnt_ack),
    .gnt_ch(gnt_ch), .gnt_rx(gnt_rx)
  );

  int vectors = 0, fails = 0, cycles = 0;
  string cur_req = "R1";
  int ack_mode = 0;       // 0 none, 1 always, 2 random
  bit ack_pulse = 0;

  // reference model state
  int m_ch [256];
  bit m_rx [256];
  int m_last, m_ptr, m_ch_g;
  bit m_en, m_valid, m_rx_g;

  // grant monitor
  int gq_ch [$];
  bit gq_rx [$];
  bit prev_valid = 0;

  initial clk = 0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, string what, longint act, longint exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) begin m_ch[i] = 0; m_rx[i] = 0; end
      m_last = 0; m_en = 0; m_ptr = 0; m_valid = 0; m_ch_g = 0; m_rx_g = 0;
    end else begin
      int nx;
      bit rdy;
      nx  = (m_ptr >= m_last) ? 0 : m_ptr + 1;
      rdy = m_rx[m_ptr] ? rx_ready[m_ch[m_ptr]] : tx_ready[m_ch[m_ptr]];
      if (!m_en) m_valid = 0;
      else if (m_valid) begin
        if (gnt_ack) begin m_valid = 0; m_ptr = nx; end
      end else if (m_ptr <= m_last && rdy) begin
        m_valid = 1; m_ch_g = m_ch[m_ptr]; m_rx_g = m_rx[m_ptr];
      end else m_ptr = nx;
      if (host_wr) begin
        if (host_addr < CTRL) begin
          for (int k = 0; k < 4; k++) begin
            m_ch[host_addr*4+k] = int'(host_wdata[k*8 +: 5]);
            m_rx[host_addr*4+k] = host_wdata[k*8+7];
          end
        end else if (host_addr == CTRL) begin
          m_last = int'(host_wdata[7:0]);
          m_en   = host_wdata[31];
        end
      end
    end
  end

  always @(negedge clk) begin
    logic [31:0] exp_rd;
    exp_rd = (host_addr == CTRL) ? {m_en, 23'd0, m_last[7:0]} : 32'd0;
    chk(cur_req, "gnt_valid", gnt_valid, m_valid);
    if (m_valid) begin
      chk(cur_req, "gnt_ch", gnt_ch, m_ch_g);
      chk(cur_req, "gnt_rx", gnt_rx, m_rx_g);
    end
    chk("R3", "host_rdata", host_rdata, exp_rd);
    if (gnt_valid && !prev_valid) begin gq_ch.push_back(gnt_ch); gq_rx.push_back(gnt_rx); end
    prev_valid = gnt_valid;
    gnt_ack = (ack_mode == 1) ? gnt_valid :
              (ack_mode == 2) ? (gnt_valid & $urandom_range(0,1)) :
              (gnt_valid & ack_pulse);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #3;
  endtask

  task automatic hw(logic [6:0] a, logic [31:0] d);
    host_wr = 1; host_addr = a; host_wdata = d;
    tick(1);
    host_wr = 0; host_addr = CTRL; host_wdata = 0;
  endtask

  task automatic clear_q();
    gq_ch.delete(); gq_rx.delete();
  endtask

  initial begin
    rst_n = 0; host_wr = 0; host_addr = CTRL; host_wdata = 0;
    tx_ready = 0; rx_ready = 0; gnt_ack = 0;
    #(3*CLK_PERIOD + 3);
    rst_n = 1;
    tick(5);
    // R1 reset state
    chk("R1", "valid after reset", gnt_valid, 0);
    chk("R1", "ctrl after reset", host_rdata, 0);
    tx_ready = 32'h1;
    hw(CTRL, 32'h8000_0000);
    tick(3);
    chk("R1", "default slot grant valid", gnt_valid, 1);
    chk("R1", "default slot ch", gnt_ch, 0);
    chk("R1", "default slot rx", gnt_rx, 0);
    // R7 disable withdraws
    cur_req = "R7";
    hw(CTRL, 32'h0000_0000);
    tick(1);
    chk("R7", "withdrawn", gnt_valid, 0);
    tick(5);
    chk("R7", "idle while disabled", gnt_valid, 0);

    // R2 / R4 / R5 ordered walk with wrap
    cur_req = "R2";
    hw(7'd0, 32'hE702_8201);
    hw(CTRL, 32'h8000_0002);
    clear_q();
    tx_ready = '1; rx_ready = '1; ack_mode = 1;
    tick(16);
    chk("R5", "grant count", gq_ch.size() >= 6, 1);
    chk("R2", "g0 ch", gq_ch[0], 1); chk("R2", "g0 rx", gq_rx[0], 0);
    chk("R2", "g1 ch", gq_ch[1], 2); chk("R2", "g1 rx", gq_rx[1], 1);
    chk("R2", "g2 ch", gq_ch[2], 2); chk("R2", "g2 rx", gq_rx[2], 0);
    chk("R5", "wrap ch", gq_ch[3], 1); chk("R5", "wrap rx", gq_rx[3], 0);
    // reserved bits ignored: slot 3 is ch7 rx with bits 6:5 set
    hw(CTRL, 32'h8000_0003);
    tx_ready = 0; rx_ready = 32'h80;
    tick(12);
    clear_q(); tick(12);
    chk("R2", "reserved ignored ch", gq_ch[0], 7);
    chk("R2", "reserved ignored rx", gq_rx[0], 1);

    // R4 skip not-ready slots
    cur_req = "R4";
    tx_ready = 32'h4; rx_ready = 0;
    tick(10); clear_q(); tick(20);
    chk("R4", "skip only 2tx", (gq_ch.size() > 2) && gq_ch[0] == 2 && gq_rx[0] == 0 && gq_ch[1] == 2, 1);

    // R6 hold until ack
    cur_req = "R6";
    ack_mode = 0; tx_ready = '1; rx_ready = '1;
    tick(6);
    chk("R6", "held valid", gnt_valid, 1);
    tx_ready = 0; rx_ready = 0;
    tick(6);
    chk("R6", "held after ready drop", gnt_valid, 1);
    ack_pulse = 1; tick(2); ack_pulse = 0; tick(2);
    chk("R6", "dropped after ack", gnt_valid, 0);

    // R5 shrink below pointer
    cur_req = "R5";
    tx_ready = '1; rx_ready = '1;
    for (int i = 0; i < 6; i++) begin ack_pulse = 1; tick(1); ack_pulse = 0; tick(3); end
    hw(CTRL, 32'h8000_0000);
    tick(4); ack_pulse = 1; tick(2); ack_pulse = 0; tick(4);
    chk("R5", "shrunk grant ch", gnt_ch, 1);

    // R8 rewrite while enabled
    cur_req = "R8";
    ack_mode = 1;
    hw(7'd0, 32'h0000_0089);
    tick(2); clear_q(); tick(10);
    chk("R8", "new slot ch", gq_ch[0], 9);
    chk("R8", "new slot rx", gq_rx[0], 1);

    // R9 bandwidth share
    cur_req = "R9";
    hw(7'd0, 32'h0503_0303);
    hw(CTRL, 32'h8000_0003);
    tick(4); clear_q();
    tick(80);
    begin
      int n3 = 0, n5 = 0;
      for (int i = 0; i < 40; i++) begin
        if (gq_ch[i] == 3) n3++;
        if (gq_ch[i] == 5) n5++;
      end
      chk("R9", "ch3 share of 40", n3, 30);
      chk("R9", "ch5 share of 40", n5, 10);
    end

    // R3 reads and out-of-range writes
    cur_req = "R3";
    host_addr = 7'd5; tick(1);
    chk("R3", "table read zero", host_rdata, 0);
    host_addr = CTRL; tick(1);
    chk("R3", "ctrl read", host_rdata, 32'h8000_0003);
    hw(7'd100, 32'h0000_0007);
    tick(1);
    chk("R3", "ctrl after stray write", host_rdata, 32'h8000_0003);

    // stress: random ready, ack and live rewrites
    cur_req = "R4";
    ack_mode = 2;
    hw(CTRL, 32'h8000_003F);
    for (int i = 0; i < 3000; i++) begin
      tx_ready = $urandom; rx_ready = $urandom;
      if ($urandom_range(0, 15) == 0) hw(7'($urandom_range(0, 15)), $urandom);
      else if ($urandom_range(0, 63) == 0) hw(CTRL, {1'b1, 23'd0, 8'($urandom_range(0, 63))});
      else tick(1);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule